// File: doc/BRIEF.md
# Word-Moving DMA Channel

This block is one DMA channel that copies a run of 32-bit words from a source address to a destination address while the processor does other work. Software sets it up through eight word-wide registers: a mode register, the two start addresses, a byte count, a timeout limit, a read-only status word and a pair of interrupt registers. The write to the byte count register is what launches the copy. Each word is moved in two bus transactions: a read from the source, then a write of the same data to the destination.

The bus side is a simple single-master memory port. The channel raises a request together with an address, a direction and, for writes, data. It holds all of them steady until the slave grants the request. It then waits for either an acknowledge or an error indication. A grant is the only back-pressure. Per-direction flags for local addresses are shown on a side pin during the matching phase. A missing acknowledge is caught by a programmable watchdog and reported apart from a slave error. Completion and failure each set a sticky interrupt bit, and the interrupt line is the masked OR of those bits.

Register offsets, selected by `cfg_addr` (a word index): 0 mode, 1 source address, 2 destination address, 3 byte count, 4 status, 5 interrupt status, 6 interrupt enable, 7 acknowledge timeout limit.

Top module: `wdma_channel`

## Requirements
- R1: After `rst` (synchronous, active high) every register reads as zero, `irq` is low and `mem_req` is low.
- R2: Writing offset 3 while idle starts a copy of count/4 words, each read from the source and then written to the destination. The low two count bits are ignored. A count below 4 sets the done bit at once, with no bus request.
- R3: With mode bit 31 set, the source address advances by 4 after each copied word; with it clear, every read uses the same source address.
- R4: With mode bit 30 set, the destination address advances by 4 after each copied word; with it clear, every write uses the same destination address, so the last word copied is what remains there.
- R5: Mode bit 29 (source local) drives `mem_local` during read requests and mode bit 28 (destination local) drives it during write requests. Bit 27 (scatter-gather off) is stored only. The mode register reads back bits 31..27 and zero elsewhere.
- R6: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R7: The low two bits written to either address register are dropped: they read back as zero and never appear on `mem_addr`.
- R8: The status word (offset 4) has bit 31 busy, bit 30 slave error seen and bit 29 acknowledge timeout seen. Bits 30 and 29 stay set until the next start clears them.
- R9: If neither acknowledge nor error arrives within limit+1 cycles after the grant cycle, the copy stops. Status bit 29 and interrupt bit 1 are set. An acknowledge in exactly the last allowed cycle is accepted.
- R10: `mem_err` during a data phase stops the copy, sets status bit 30 and interrupt bit 1, and writes nothing more.
- R11: Interrupt status bit 0 (done) is set when the last word is written. Writing 1 to an interrupt status bit clears it. `irq` is the OR over bits 1..0 of status AND enable.
- R12: While busy, writes to offsets 0, 1, 2, 3 and 7 are ignored: register contents stay the same and no new copy starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_local | output | 1 | Local-address flag of the current phase |
| mem_gnt | input | 1 | Slave accepts the request in this cycle |
| mem_ack | input | 1 | Data phase complete |
| mem_err | input | 1 | Data phase failed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The copy is swept over all four increment combinations, with lengths of one to five words, acknowledge latencies of zero to two cycles, grant delays of zero and one cycle, and misaligned address and count low bits. The destination region is compared word by word with an arithmetic model. This separates correct stepping from a fixed address, and it catches an off-by-one word count or a missed last word. Separate patterns hold the acknowledge back for exactly the limit and for one cycle more, answer with a slave error, and write registers in the middle of a copy. These tell the two failure kinds apart, show where the timeout boundary lies, and show that writes made while busy are locked out.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT
  } eng_state_t;

  localparam logic [2:0] OFS_MODE   = 3'd0;
  localparam logic [2:0] OFS_SRC    = 3'd1;
  localparam logic [2:0] OFS_DST    = 3'd2;
  localparam logic [2:0] OFS_COUNT  = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_ISR    = 3'd5;
  localparam logic [2:0] OFS_IER    = 3'd6;
  localparam logic [2:0] OFS_TMO    = 3'd7;

  localparam int WORD_BYTES = 4;
  localparam int IRQ_BITS   = 2;
endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int TW  = 16,
  parameter int WCW = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [2:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic           irq,
  input  logic           busy,
  input  logic           done_set,
  input  logic           berr_set,
  input  logic           tmo_set,
  output logic           start,
  output logic [WCW-1:0] start_words,
  output logic           src_inc,
  output logic           dst_inc,
  output logic           src_loc,
  output logic           dst_loc,
  output logic [AW-1:0]  src_base,
  output logic [AW-1:0]  dst_base,
  output logic [TW-1:0]  tmo_lim
);
  logic [4:0]          mode_q;
  logic [AW-1:0]       src_q, dst_q;
  logic [31:0]         cnt_q;
  logic [TW-1:0]       tmo_q;
  logic [IRQ_BITS-1:0] isr_q, ier_q, isr_set, isr_clr;
  logic                berr_q, tflag_q, cfg_ok;

  assign cfg_ok      = cfg_wr && !busy;
  assign start       = cfg_ok && (cfg_addr == OFS_COUNT);
  assign start_words = cfg_wdata[31:2];
  assign isr_set     = {berr_set | tmo_set, done_set};
  assign isr_clr     = (cfg_wr && cfg_addr == OFS_ISR) ? cfg_wdata[IRQ_BITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      isr_q   <= '0;
      ier_q   <= '0;
      berr_q  <= 1'b0;
      tflag_q <= 1'b0;
    end else begin
      if (cfg_ok) begin
        case (cfg_addr)
          OFS_MODE:  mode_q <= cfg_wdata[31:27];
          OFS_SRC:   src_q  <= {cfg_wdata[AW-1:2], 2'b00};
          OFS_DST:   dst_q  <= {cfg_wdata[AW-1:2], 2'b00};
          OFS_COUNT: cnt_q  <= {cfg_wdata[31:2], 2'b00};
          OFS_TMO:   tmo_q  <= cfg_wdata[TW-1:0];
          default: ;
        endcase
      end
      if (cfg_wr && cfg_addr == OFS_IER) ier_q <= cfg_wdata[IRQ_BITS-1:0];
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (start) begin
        berr_q  <= 1'b0;
        tflag_q <= 1'b0;
      end else begin
        if (berr_set) berr_q  <= 1'b1;
        if (tmo_set)  tflag_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_MODE:   cfg_rdata = {mode_q, 27'd0};
      OFS_SRC:    cfg_rdata = 32'(src_q);
      OFS_DST:    cfg_rdata = 32'(dst_q);
      OFS_COUNT:  cfg_rdata = cnt_q;
      OFS_STATUS: cfg_rdata = {busy, berr_q, tflag_q, 29'd0};
      OFS_ISR:    cfg_rdata = 32'(isr_q);
      OFS_IER:    cfg_rdata = 32'(ier_q);
      default:    cfg_rdata = 32'(tmo_q);
    endcase
  end

  assign irq      = |(isr_q & ier_q);
  assign src_inc  = mode_q[4];
  assign dst_inc  = mode_q[3];
  assign src_loc  = mode_q[2];
  assign dst_loc  = mode_q[1];
  assign src_base = src_q;
  assign dst_base = dst_q;
  assign tmo_lim  = tmo_q;

  // R11
  isr_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == OFS_ISR && cfg_wdata[0] && !done_set) |=> !isr_q[0]);

  // R12
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr) |=> ($stable(src_q) && $stable(dst_q) && $stable(mode_q) && $stable(tmo_q)));
endmodule

// File: rtl/wdma_addr_seq.sv
module wdma_addr_seq
  import wdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  input  logic          incr,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)               addr <= '0;
    else if (load)         addr <= base;
    else if (step && incr) addr <= addr + AW'(WORD_BYTES);
  end

  // R3 R4
  fixed_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !incr && !load) |=> $stable(addr));

  // R7
  aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
    addr[1:0] == 2'b00);
endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
  import wdma_pkg::*;
#(
  parameter int TW  = 16,
  parameter int WCW = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [WCW-1:0] start_words,
  input  logic [TW-1:0]  tmo_lim,
  input  logic           mem_gnt,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [31:0]    mem_rdata,
  output logic           busy,
  output logic           rd_phase,
  output logic           done_set,
  output logic           berr_set,
  output logic           tmo_set,
  output logic           step,
  output logic           mem_req,
  output logic           mem_we,
  output logic [31:0]    mem_wdata
);
  eng_state_t     state_q;
  logic [WCW-1:0] left_q;
  logic [TW-1:0]  wait_q;
  logic [31:0]    data_q;
  logic           waiting, expired;

  assign busy      = (state_q != ST_IDLE);
  assign waiting   = (state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT);
  assign mem_req   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we    = (state_q == ST_WR_REQ) || (state_q == ST_WR_WAIT);
  assign rd_phase  = !mem_we;
  assign mem_wdata = data_q;
  assign expired   = waiting && !mem_err && !mem_ack && (wait_q == tmo_lim);
  assign berr_set  = waiting && mem_err;
  assign tmo_set   = expired;
  assign step      = (state_q == ST_WR_WAIT) && mem_ack && !mem_err;
  assign done_set  = (start && start_words == '0) || (step && left_q == WCW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      wait_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start && start_words != '0) begin
          left_q  <= start_words;
          state_q <= ST_RD_REQ;
        end
        ST_RD_REQ, ST_WR_REQ: if (mem_gnt) begin
          wait_q  <= '0;
          state_q <= (state_q == ST_RD_REQ) ? ST_RD_WAIT : ST_WR_WAIT;
        end
        default: begin
          if (mem_err || expired) begin
            state_q <= ST_IDLE;
          end else if (mem_ack) begin
            if (state_q == ST_RD_WAIT) begin
              data_q  <= mem_rdata;
              state_q <= ST_WR_REQ;
            end else begin
              left_q  <= left_q - WCW'(1);
              state_q <= (left_q == WCW'(1)) ? ST_IDLE : ST_RD_REQ;
            end
          end else begin
            wait_q <= wait_q + TW'(1);
          end
        end
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (wait_q <= tmo_lim));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done_set || berr_set || tmo_set));
endmodule

// File: rtl/wdma_channel.sv
module wdma_channel
  import wdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_local,
  input  logic          mem_gnt,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata
);
  localparam int WCW = 32 - $clog2(WORD_BYTES);

  logic           busy, done_set, berr_set, tmo_set, start, step, rd_phase;
  logic           src_inc, dst_inc, src_loc, dst_loc;
  logic [WCW-1:0] start_words;
  logic [AW-1:0]  src_base, dst_base, src_addr, dst_addr;
  logic [TW-1:0]  tmo_lim;

  wdma_regs #(.AW(AW), .TW(TW), .WCW(WCW)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .busy(busy), .done_set(done_set), .berr_set(berr_set), .tmo_set(tmo_set),
    .start(start), .start_words(start_words),
    .src_inc(src_inc), .dst_inc(dst_inc), .src_loc(src_loc), .dst_loc(dst_loc),
    .src_base(src_base), .dst_base(dst_base), .tmo_lim(tmo_lim)
  );

  wdma_addr_seq #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(start), .base(src_base),
    .step(step), .incr(src_inc), .addr(src_addr)
  );

  wdma_addr_seq #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(start), .base(dst_base),
    .step(step), .incr(dst_inc), .addr(dst_addr)
  );

  wdma_engine #(.TW(TW), .WCW(WCW)) u_eng (
    .clk(clk), .rst(rst), .start(start), .start_words(start_words),
    .tmo_lim(tmo_lim), .mem_gnt(mem_gnt), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .busy(busy),
    .rd_phase(rd_phase), .done_set(done_set), .berr_set(berr_set),
    .tmo_set(tmo_set), .step(step), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  assign mem_addr  = rd_phase ? src_addr : dst_addr;
  assign mem_local = rd_phase ? src_loc  : dst_loc;

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> $stable(mem_addr));
endmodule

// File: tb/sim_wdma_channel.sv
module sim_wdma_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, mem_req, mem_we, mem_local, mem_gnt, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  wdma_channel u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_local(mem_local), .mem_gnt(mem_gnt),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  // memory slave model
  logic [31:0] mem [64];
  int  lat = 0, gdel = 0, gcnt = 0, dc = 0;
  bit  hang = 0, err_mode = 0, flush = 0;
  bit  ph = 0, p_we = 0;
  logic [5:0]  p_idx = '0;
  logic [31:0] p_wd = '0;
  int  grants = 0, local_bad = 0;
  bit  exp_sloc = 0, exp_dloc = 0;

  assign mem_gnt   = mem_req && (gcnt >= gdel);
  assign mem_ack   = ph && !hang && !err_mode && (dc == lat);
  assign mem_err   = ph && err_mode && (dc == lat);
  assign mem_rdata = mem[p_idx];

  always @(posedge clk) begin
    if (rst || flush) begin
      ph <= 0; gcnt <= 0; dc <= 0;
    end else begin
      gcnt <= (mem_req && !mem_gnt) ? gcnt + 1 : 0;
      if (mem_req && mem_gnt) begin
        ph <= 1; dc <= 0; p_we <= mem_we; p_idx <= mem_addr[7:2]; p_wd <= mem_wdata;
        grants = grants + 1;
        if (mem_local !== (mem_we ? exp_dloc : exp_sloc)) local_bad = local_bad + 1;
      end else if (ph) begin
        if (mem_ack || mem_err) begin
          ph <= 0;
          if (p_we && mem_ack) mem[p_idx] <= p_wd;
        end else dc <= dc + 1;
      end
    end
  end

  function automatic logic [31:0] srcval(input int i);
    return 32'h5A00_0000 + 32'(i * 7 + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int t = 0; t < 2000; t++) begin
      rd(3'd4, s);
      if (!s[31]) return;
      @(negedge clk);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] <= (i < 32) ? srcval(i) : 32'h0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] mode, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] tmo);
    wr(3'd0, mode); wr(3'd1, s); wr(3'd2, d); wr(3'd7, tmo);
    wr(3'd6, 32'h3); wr(3'd5, 32'h3);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R1 reg", v, 32'h0);
    end
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 req", {31'd0, mem_req}, 32'h0);

    // R5 mode readback
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R5 mode", v, 32'hF800_0000);

    // Sweep R2 R3 R4 R5 R7 R11
    for (int mode = 0; mode < 4; mode++)
      for (int n = 1; n <= 5; n++)
        for (int l = 0; l < 3; l++) begin
          int sb, db, si;
          logic [31:0] e;
          bit si_inc, di_inc;
          si_inc = mode[1]; di_inc = mode[0];
          sb = n % 3; db = mode;
          lat = l; gdel = n % 2;
          exp_sloc = n[0]; exp_dloc = !n[0];
          local_bad = 0;
          fill_mem();
          setup({si_inc, di_inc, exp_sloc, exp_dloc, 28'd0}, 32'(sb * 4 + 1),
                32'(128 + db * 4 + 2), 32'd8);
          wr(3'd3, 32'(n * 4 + mode));
          wait_idle();
          for (int k = 0; k < 16; k++) begin
            if (di_inc) begin
              si = si_inc ? sb + k : sb;
              e = (k < n) ? srcval(si) : 32'h0;
            end else begin
              si = si_inc ? sb + n - 1 : sb;
              e = (k == 0) ? srcval(si) : 32'h0;
            end
            if (k < db) e = 32'h0;
            else if (!di_inc && k != db) e = 32'h0;
            else if (!di_inc) e = srcval(si);
            else e = (k - db < n) ? srcval(si_inc ? sb + k - db : sb) : 32'h0;
            check(di_inc ? "R4 R3 dst incr" : "R4 R3 dst fixed", mem[32 + k], e);
          end
          rd(3'd5, v); check("R11 done", v, 32'h1);
          check("R11 irq", {31'd0, irq}, 32'h1);
          rd(3'd4, v); check("R8 status", v, 32'h0);
          rd(3'd1, v); check("R7 src align", v, 32'(sb * 4));
          check("R5 local", 32'(local_bad), 32'h0);
        end

    // R11 W1C and masking
    wr(3'd5, 32'h1); rd(3'd5, v); check("R11 w1c", v, 32'h0);
    check("R11 irq clr", {31'd0, irq}, 32'h0);

    // R2 zero count
    lat = 0; gdel = 0; grants = 0;
    wr(3'd6, 32'h0); wr(3'd3, 32'h3);
    rd(3'd5, v); check("R2 zero done", v, 32'h1);
    rd(3'd4, v); check("R2 zero idle", v, 32'h0);
    check("R2 zero bus", 32'(grants), 32'h0);
    check("R11 masked", {31'd0, irq}, 32'h0);

    // R12 writes while busy
    fill_mem(); lat = 6; grants = 0; exp_sloc = 0; exp_dloc = 0;
    setup(32'hC000_0000, 32'h0, 32'h80, 32'd8);
    wr(3'd3, 32'd8);
    wr(3'd1, 32'h40); wr(3'd3, 32'd40); wr(3'd7, 32'd1);
    rd(3'd4, v); check("R8 busy", v, 32'h8000_0000);
    wait_idle();
    rd(3'd1, v); check("R12 src kept", v, 32'h0);
    rd(3'd7, v); check("R12 tmo kept", v, 32'd8);
    check("R12 no restart", 32'(grants), 32'd4);
    check("R12 data", mem[33], srcval(1));

    // R9 boundary: ack in last allowed cycle
    fill_mem(); lat = 3;
    setup(32'h0, 32'h0, 32'h80, 32'd3);
    wr(3'd3, 32'd4); wait_idle();
    rd(3'd5, v); check("R9 edge ok", v, 32'h1);
    check("R9 edge data", mem[32], srcval(0));

    // R9 one cycle late
    fill_mem(); lat = 4;
    setup(32'h0, 32'h0, 32'h80, 32'd3);
    wr(3'd3, 32'd4); wait_idle();
    rd(3'd4, v); check("R9 late status", v, 32'h2000_0000);
    rd(3'd5, v); check("R9 late isr", v, 32'h2);
    check("R9 no write", mem[32], 32'h0);
    flush = 1; @(negedge clk); flush = 0;

    // R9 hang
    hang = 1; lat = 0;
    setup(32'h0, 32'h0, 32'h80, 32'd5);
    wr(3'd3, 32'd4); wait_idle();
    rd(3'd4, v); check("R9 hang status", v, 32'h2000_0000);
    rd(3'd5, v); check("R9 hang isr", v, 32'h2);
    check("R11 err irq", {31'd0, irq}, 32'h1);
    hang = 0; flush = 1; @(negedge clk); flush = 0;

    // R10 slave error
    fill_mem(); err_mode = 1; lat = 1;
    setup(32'hC000_0000, 32'h0, 32'h80, 32'd8);
    wr(3'd3, 32'd12); wait_idle();
    err_mode = 0;
    rd(3'd4, v); check("R10 status", v, 32'h4000_0000);
    rd(3'd5, v); check("R10 isr", v, 32'h2);
    check("R10 no write", mem[32], 32'h0);

    // R8 next start clears error bits
    setup(32'hC000_0000, 32'h0, 32'h80, 32'd8);
    wr(3'd3, 32'd4); wait_idle();
    rd(3'd4, v); check("R8 cleared", v, 32'h0);
    check("R8 data", mem[32], srcval(0));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule